// File: doc/BRIEF.md
# Integer Multiply-Accumulate Execution Unit

This unit decodes and executes a family of 32x32-bit multiply instructions for a 64-bit integer pipeline. It keeps a 64-bit accumulator split across two architectural registers. The upper half of the accumulator sits in bits 31:0 of HI and the lower half sits in bits 31:0 of LO. Each instruction forms a signed or unsigned product of the low 32 bits of two source operands. The product is then loaded into the accumulator, added to it, subtracted from it, or negated and loaded. One accumulator half, sign-extended to 64 bits, may be returned for the destination register.

The issuing stage presents an instruction word, a valid strobe and the two source register values. On the next clock edge the unit updates HI and LO. For one cycle after that edge it shows a write-back value, a destination index and a write strobe. An encoding it does not recognise raises an illegal flag for one cycle and changes nothing.

Top module: `mac_exec_unit`

## Requirements
- R1: While rstN is low, and after reset, HI, LO, wbEnable, wbData and illegalOp read zero.
- R2: Primary opcode (bits 31:26) 000000, function (bits 5:0) 101000, rd (bits 15:11) 0 and sa (bits 10:6) 0 adds the signed product to the accumulator and leaves wbEnable low.
- R3: Function 101001 with rd and sa both 0 adds the signed product to the full 64-bit LO register. HI is left alone and wbEnable stays low.
- R4: Function 101000 loads the product into the accumulator for these sa values: 00100 (signed, low half returned), 00101 (unsigned, low), 01100 (signed, high) and 01101 (unsigned, high).
- R5: Function 101000 adds the product to the accumulator for these sa values: 00010 (signed, low half returned), 00011 (unsigned, low), 01010 (signed, high) and 01011 (unsigned, high).
- R6: Function 011000 (signed) or 011001 (unsigned) loads zero minus the product. Sa 00011 returns the low half and sa 01011 returns the high half.
- R7: Function 011000 or 011001 subtracts the product from the accumulator. Sa 00111 returns the low half and sa 01111 returns the high half.
- R8: In the cycle after a write-back form is issued, wbEnable is 1, wbIndex equals rd, and wbData is the selected 32-bit accumulator half sign-extended to 64 bits. This applies to the unsigned forms as well.
- R9: Only bits 31:0 of each source feed the multiplier. Accumulator arithmetic wraps modulo 2^64.
- R10: After any split-accumulator update, bits 63:32 of HI and of LO copy bit 31 of their register. HI always holds this form.
- R11: A valid instruction with a nonzero primary opcode, or with a function/sa/rd combination not listed above, sets illegalOp for one cycle. It leaves HI and LO unchanged and keeps wbEnable low.
- R12: While instrValid is low, HI and LO hold and wbEnable and illegalOp stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrValid | input | 1 | Instruction word is valid this cycle |
| instrWord | input | 32 | Instruction word |
| srcA | input | 64 | First source register value (rs) |
| srcB | input | 64 | Second source register value (rt) |
| hiOut | output | 64 | HI register |
| loOut | output | 64 | LO register |
| wbIndex | output | 5 | Destination register index |
| wbData | output | 64 | Write-back value |
| wbEnable | output | 1 | Write-back strobe |
| illegalOp | output | 1 | Unrecognised encoding seen |

## Verification
The bench multiplies all-ones operands in both signednesses and returns the high half of an unsigned product. A design that zero-extends unsigned results, or one that builds a single multiplier with the wrong sign bit, gives a wrong upper word there. It puts junk in bits 63:32 of both sources, which shows a design that feeds the full register into the multiplier. It drives the accumulator past zero and past 2^64, which catches a borrow or carry that is dropped between LO and HI. It also uses the LO-only form, whose result must not be folded back into the split accumulator. The near-miss encodings (sa 00001, nonzero rd on the plain form, nonzero primary opcode) must leave the state untouched, which exposes a decoder that matches only part of the fields.

// File: rtl/mac_pkg.sv
package mac_pkg;
  parameter int XLEN   = 64;
  parameter int IDX_W  = 5;
  localparam int HALF  = XLEN / 2;

  typedef enum logic [1:0] {
    ACC_LOAD    = 2'd0,
    ACC_ADD     = 2'd1,
    ACC_SUB     = 2'd2,
    ACC_NEGLOAD = 2'd3
  } accOp_e;

  typedef struct packed {
    logic   commit;     // update accumulator this edge
    logic   loOnly;     // add product to full LO register only
    logic   signedMul;  // signed operands
    accOp_e accOp;
    logic   pickHigh;   // return upper half
    logic   writeBack;  // drive write-back strobe
    logic   illegal;    // unrecognised encoding
  } macCtrl_t;
endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
#(
  parameter int IW = IDX_W
) (
  input  logic          instrValid,
  input  logic [5:0]    opField,
  input  logic [IW-1:0] rdField,
  input  logic [4:0]    saField,
  input  logic [5:0]    fnField,
  output macCtrl_t      ctrl
);
  logic    legal;
  logic    sgn, hiSel, wb, loOnly;
  accOp_e  op;

  always_comb begin
    legal  = 1'b0;
    sgn    = 1'b1;
    hiSel  = 1'b0;
    wb     = 1'b1;
    loOnly = 1'b0;
    op     = ACC_ADD;
    if (opField == 6'b000000) begin
      unique case (fnField)
        6'b101000: begin
          unique case (saField)
            5'b00000: begin legal = (rdField == '0); wb = 1'b0; end
            5'b00100: begin legal = 1'b1; op = ACC_LOAD; end
            5'b00101: begin legal = 1'b1; op = ACC_LOAD; sgn = 1'b0; end
            5'b01100: begin legal = 1'b1; op = ACC_LOAD; hiSel = 1'b1; end
            5'b01101: begin legal = 1'b1; op = ACC_LOAD; hiSel = 1'b1; sgn = 1'b0; end
            5'b00010: begin legal = 1'b1; end
            5'b00011: begin legal = 1'b1; sgn = 1'b0; end
            5'b01010: begin legal = 1'b1; hiSel = 1'b1; end
            5'b01011: begin legal = 1'b1; hiSel = 1'b1; sgn = 1'b0; end
            default:  legal = 1'b0;
          endcase
        end
        6'b101001: begin
          legal  = (rdField == '0) && (saField == 5'b00000);
          loOnly = 1'b1;
          wb     = 1'b0;
        end
        6'b011000, 6'b011001: begin
          sgn = ~fnField[0];
          unique case (saField)
            5'b00011: begin legal = 1'b1; op = ACC_NEGLOAD; end
            5'b01011: begin legal = 1'b1; op = ACC_NEGLOAD; hiSel = 1'b1; end
            5'b00111: begin legal = 1'b1; op = ACC_SUB; end
            5'b01111: begin legal = 1'b1; op = ACC_SUB; hiSel = 1'b1; end
            default:  legal = 1'b0;
          endcase
        end
        default: legal = 1'b0;
      endcase
    end
  end

  always_comb begin
    ctrl.commit    = instrValid & legal;
    ctrl.loOnly    = loOnly;
    ctrl.signedMul = sgn;
    ctrl.accOp     = op;
    ctrl.pickHigh  = hiSel;
    ctrl.writeBack = instrValid & legal & wb;
    ctrl.illegal   = instrValid & ~legal;
  end
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  macCtrl_t      ctrl,
  input  logic [IW-1:0] rdField,
  input  logic [W/2-1:0] opA,
  input  logic [W/2-1:0] opB,
  output logic [W-1:0]  hiReg,
  output logic [W-1:0]  loReg,
  output logic [IW-1:0] wbIdxReg,
  output logic [W-1:0]  wbDataReg,
  output logic          wbEnReg,
  output logic          illegalReg
);
  localparam int H = W / 2;

  logic signed [H:0]     extA, extB;
  logic signed [2*H+1:0] prodFull;
  logic [W-1:0]          product, accNow, accNext, loNext;
  logic [1:0]            unusedProdTop;

  // one multiplier for both signednesses: extend by one bit
  assign extA     = {ctrl.signedMul & opA[H-1], opA};
  assign extB     = {ctrl.signedMul & opB[H-1], opB};
  assign prodFull = extA * extB;
  assign product  = prodFull[W-1:0];
  assign unusedProdTop = prodFull[2*H+1:2*H];

  assign accNow = {hiReg[H-1:0], loReg[H-1:0]};

  always_comb begin
    unique case (ctrl.accOp)
      ACC_LOAD:    accNext = product;
      ACC_ADD:     accNext = accNow + product;
      ACC_SUB:     accNext = accNow - product;
      ACC_NEGLOAD: accNext = '0 - product;
      default:     accNext = product;
    endcase
  end

  assign loNext = loReg + product;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiReg      <= '0;
      loReg      <= '0;
      wbIdxReg   <= '0;
      wbDataReg  <= '0;
      wbEnReg    <= 1'b0;
      illegalReg <= 1'b0;
    end else begin
      wbEnReg    <= ctrl.writeBack;
      illegalReg <= ctrl.illegal;
      if (ctrl.commit) begin
        if (ctrl.loOnly) begin
          loReg <= loNext;
        end else begin
          hiReg <= {{H{accNext[W-1]}}, accNext[W-1:H]};
          loReg <= {{H{accNext[H-1]}}, accNext[H-1:0]};
        end
      end
      if (ctrl.writeBack) begin
        wbIdxReg  <= rdField;
        wbDataReg <= ctrl.pickHigh ? {{H{accNext[W-1]}}, accNext[W-1:H]}
                                   : {{H{accNext[H-1]}}, accNext[H-1:0]};
      end
    end
  end
endmodule

// File: rtl/mac_exec_unit.sv
module mac_exec_unit
  import mac_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             instrValid,
  input  logic [31:0]      instrWord,
  input  logic [XLEN-1:0]  srcA,
  input  logic [XLEN-1:0]  srcB,
  output logic [XLEN-1:0]  hiOut,
  output logic [XLEN-1:0]  loOut,
  output logic [IDX_W-1:0] wbIndex,
  output logic [XLEN-1:0]  wbData,
  output logic             wbEnable,
  output logic             illegalOp
);
  macCtrl_t ctrl;
  logic     unusedBits;

  // register specifiers arrive pre-read as srcA/srcB; upper source bits unused
  assign unusedBits = ^{instrWord[25:16], srcA[XLEN-1:HALF], srcB[XLEN-1:HALF]};

  mac_ctrl #(.IW(IDX_W)) u_ctrl (
    .instrValid (instrValid),
    .opField    (instrWord[31:26]),
    .rdField    (instrWord[15:11]),
    .saField    (instrWord[10:6]),
    .fnField    (instrWord[5:0]),
    .ctrl       (ctrl)
  );

  mac_datapath #(.W(XLEN), .IW(IDX_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .rdField    (instrWord[15:11]),
    .opA        (srcA[HALF-1:0]),
    .opB        (srcB[HALF-1:0]),
    .hiReg      (hiOut),
    .loReg      (loOut),
    .wbIdxReg   (wbIndex),
    .wbDataReg  (wbData),
    .wbEnReg    (wbEnable),
    .illegalReg (illegalOp)
  );
endmodule

// File: rtl/mac_exec_unit_chk.sv
module mac_exec_unit_chk
  import mac_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             instrValid,
  input logic [31:0]      instrWord,
  input logic [XLEN-1:0]  srcA,
  input logic [XLEN-1:0]  srcB,
  input logic [XLEN-1:0]  hiOut,
  input logic [XLEN-1:0]  loOut,
  input logic [IDX_W-1:0] wbIndex,
  input logic [XLEN-1:0]  wbData,
  input logic             wbEnable,
  input logic             illegalOp
);
  assert_illegal_no_state_R11: assert property (@(posedge clk) disable iff (!rstN)
    illegalOp |-> (hiOut == $past(hiOut)) && (loOut == $past(loOut)));

  assert_illegal_no_wb_R11: assert property (@(posedge clk) disable iff (!rstN)
    illegalOp |-> !wbEnable);

  assert_idle_holds_R12: assert property (@(posedge clk) disable iff (!rstN)
    !instrValid |=> $stable(hiOut) && $stable(loOut) && !wbEnable && !illegalOp);

  assert_wb_matches_half_R8: assert property (@(posedge clk) disable iff (!rstN)
    wbEnable |-> (wbData == hiOut) || (wbData == loOut));

  assert_hi_sign_extended_R10: assert property (@(posedge clk) disable iff (!rstN)
    hiOut[XLEN-1:HALF] == {HALF{hiOut[HALF-1]}});

  assert_wb_index_R8: assert property (@(posedge clk) disable iff (!rstN)
    wbEnable |-> wbIndex == $past(instrWord[15:11]));
endmodule

bind mac_exec_unit mac_exec_unit_chk u_chk (.*);

// File: tb/mac_exec_unit_tb.sv
`timescale 1ns/1ps
module mac_exec_unit_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        instrValid;
  logic [31:0] instrWord;
  logic [63:0] srcA, srcB;
  logic [63:0] hiOut, loOut, wbData;
  logic [4:0]  wbIndex;
  logic        wbEnable, illegalOp;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [63:0] mHi = '0, mLo = '0;

  always #4 clk = ~clk;

  mac_exec_unit u_dut (.*);

  task automatic check64(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] sx(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  // issue one instruction and compare against the requirement model
  task automatic runOp(input string tag, input logic [5:0] opc, input logic [5:0] fn,
                       input logic [4:0] rd, input logic [4:0] sa,
                       input logic [63:0] a, input logic [63:0] b, input logic v);
    logic legal = 1'b0, sgn = 1'b1, hiSel = 1'b0, wb = 1'b1, loOnly = 1'b0;
    int   mode = 1; // 0 load, 1 add, 2 sub, 3 neg-load
    logic [63:0] prod, acc, nxt, expWb;
    @(negedge clk);
    instrWord  = {opc, 5'd7, 5'd9, rd, sa, fn};
    srcA       = a;
    srcB       = b;
    instrValid = v;
    @(posedge clk);
    @(negedge clk);
    instrValid = 1'b0;
    if (opc == 6'd0) begin
      if (fn == 6'b101000) begin
        case (sa)
          5'b00000: begin legal = (rd == 0); wb = 0; end
          5'b00100: begin legal = 1; mode = 0; end
          5'b00101: begin legal = 1; mode = 0; sgn = 0; end
          5'b01100: begin legal = 1; mode = 0; hiSel = 1; end
          5'b01101: begin legal = 1; mode = 0; hiSel = 1; sgn = 0; end
          5'b00010: legal = 1;
          5'b00011: begin legal = 1; sgn = 0; end
          5'b01010: begin legal = 1; hiSel = 1; end
          5'b01011: begin legal = 1; hiSel = 1; sgn = 0; end
          default: legal = 0;
        endcase
      end else if (fn == 6'b101001) begin
        legal = (rd == 0) && (sa == 0); loOnly = 1; wb = 0;
      end else if (fn == 6'b011000 || fn == 6'b011001) begin
        sgn = (fn == 6'b011000);
        case (sa)
          5'b00011: begin legal = 1; mode = 3; end
          5'b01011: begin legal = 1; mode = 3; hiSel = 1; end
          5'b00111: begin legal = 1; mode = 2; end
          5'b01111: begin legal = 1; mode = 2; hiSel = 1; end
          default: legal = 0;
        endcase
      end
    end
    if (sgn) prod = 64'(longint'($signed(a[31:0])) * longint'($signed(b[31:0])));
    else     prod = {32'd0, a[31:0]} * {32'd0, b[31:0]};
    acc = {mHi[31:0], mLo[31:0]};
    case (mode)
      0: nxt = prod;
      1: nxt = acc + prod;
      2: nxt = acc - prod;
      default: nxt = 64'd0 - prod;
    endcase
    expWb = hiSel ? sx(nxt[63:32]) : sx(nxt[31:0]);
    if (v && legal) begin
      if (loOnly) mLo = mLo + prod;
      else begin mHi = sx(nxt[63:32]); mLo = sx(nxt[31:0]); end
    end
    check64(tag, "HI", hiOut, mHi);
    check64(tag, "LO", loOut, mLo);
    check64(tag, "illegal", {63'd0, illegalOp}, {63'd0, v && !legal});
    check64(tag, "wbEnable", {63'd0, wbEnable}, {63'd0, v && legal && wb});
    if (v && legal && wb) begin
      check64(tag, "wbData", wbData, expWb);
      check64(tag, "wbIndex", {59'd0, wbIndex}, {59'd0, rd});
    end
  endtask

  task automatic t_reset_r1;
    check64("R1", "HI", hiOut, 64'd0);
    check64("R1", "LO", loOut, 64'd0);
    check64("R1", "wbEnable", {63'd0, wbEnable}, 64'd0);
    check64("R1", "wbData", wbData, 64'd0);
    check64("R1", "illegal", {63'd0, illegalOp}, 64'd0);
  endtask

  task automatic t_load_r4;
    // R9: junk in upper source bits
    runOp("R4", 6'd0, 6'b101000, 5'd3, 5'b00100, 64'hDEAD_BEEF_FFFF_FFFD, 64'h1234_5678_0000_0007, 1);
    check64("R4", "hand LO", loOut, 64'hFFFF_FFFF_FFFF_FFEB);
    runOp("R4", 6'd0, 6'b101000, 5'd4, 5'b00101, 64'hFFFF_FFFF, 64'hFFFF_FFFF, 1);
    runOp("R8", 6'd0, 6'b101000, 5'd5, 5'b01101, 64'hFFFF_FFFF, 64'hFFFF_FFFF, 1);
    check64("R8", "hand unsigned hi wb", wbData, 64'hFFFF_FFFF_FFFF_FFFE);
    runOp("R4", 6'd0, 6'b101000, 5'd6, 5'b01100, 64'hFFFF_FFFF, 64'hFFFF_FFFF, 1);
    check64("R4", "hand signed hi", hiOut, 64'd0);
  endtask

  task automatic t_accum_r5;
    runOp("R2", 6'd0, 6'b101000, 5'd0, 5'b00000, 64'h7FFF_FFFF, 64'h7FFF_FFFF, 1);
    runOp("R5", 6'd0, 6'b101000, 5'd8, 5'b00010, 64'h8000_0000, 64'h0000_0003, 1);
    runOp("R5", 6'd0, 6'b101000, 5'd9, 5'b00011, 64'hFFFF_FFFF, 64'hFFFF_FFFF, 1);
    runOp("R5", 6'd0, 6'b101000, 5'd10, 5'b01010, 64'h0001_0000, 64'hFFFF_0000, 1);
    runOp("R9", 6'd0, 6'b101000, 5'd11, 5'b01011, 64'hAAAA_0000_FFFF_FFFF, 64'h5555_0000_FFFF_FFFF, 1);
  endtask

  task automatic t_negate_r6_r7;
    runOp("R6", 6'd0, 6'b011000, 5'd12, 5'b00011, 64'd5, 64'd6, 1);
    check64("R6", "hand LO", loOut, 64'hFFFF_FFFF_FFFF_FFE2);
    runOp("R6", 6'd0, 6'b011001, 5'd13, 5'b01011, 64'hFFFF_FFFF, 64'd2, 1);
    runOp("R7", 6'd0, 6'b011000, 5'd14, 5'b00111, 64'hFFFF_FFFF, 64'd9, 1);
    runOp("R7", 6'd0, 6'b011001, 5'd15, 5'b01111, 64'hFFFF_FFFF, 64'hFFFF_FFFF, 1);
    runOp("R9", 6'd0, 6'b011001, 5'd16, 5'b00111, 64'hFFFF_FFFF, 64'hFFFF_FFFF, 1);
    runOp("R10", 6'd0, 6'b101000, 5'd17, 5'b00010, 64'd1, 64'h8000_0000, 1);
  endtask

  task automatic t_lo_only_r3;
    runOp("R3", 6'd0, 6'b101000, 5'd1, 5'b00100, 64'd3, 64'd4, 1);
    runOp("R3", 6'd0, 6'b101001, 5'd0, 5'b00000, 64'h7FFF_FFFF, 64'h7FFF_FFFF, 1);
    check64("R3", "hand LO", loOut, 64'h3FFF_FFFF_0000_000D);
    runOp("R3", 6'd0, 6'b101000, 5'd2, 5'b00010, 64'd1, 64'd1, 1);
  endtask

  task automatic t_illegal_r11_r12;
    runOp("R11", 6'd0, 6'b101000, 5'd3, 5'b00001, 64'd9, 64'd9, 1);
    runOp("R11", 6'd0, 6'b101000, 5'd3, 5'b00000, 64'd9, 64'd9, 1);
    runOp("R11", 6'd1, 6'b101000, 5'd3, 5'b00100, 64'd9, 64'd9, 1);
    runOp("R11", 6'd0, 6'b101001, 5'd0, 5'b00100, 64'd9, 64'd9, 1);
    runOp("R11", 6'd0, 6'b011000, 5'd3, 5'b00010, 64'd9, 64'd9, 1);
    runOp("R12", 6'd0, 6'b101000, 5'd3, 5'b00100, 64'd9, 64'd9, 0);
  endtask

  initial begin
    rstN = 1'b0; instrValid = 1'b0; instrWord = '0; srcA = '0; srcB = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset_r1();
    rstN = 1'b1;
    @(negedge clk);
    t_reset_r1();
    t_load_r4();
    t_accum_r5();
    t_negate_r6_r7();
    t_lo_only_r3();
    t_illegal_r11_r12();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule